// File: doc/BRIEF.md
# Integer Arithmetic Register Window

This block gives a CPU that has no hardware arithmetic of its own a small set of integer units, reached through a byte-wide memory-mapped window. Five units sit in the window: an unsigned and a signed 16x16 multiplier, an unsigned and a signed 16/16 divider, and a 32-bit adder. Software writes operand bytes into the window and then reads result bytes back from fixed offsets. No start command is given and no busy flag is polled.

Operands are held in byte registers. Every result is formed combinationally from the stored operands. A result read on any bus cycle after the cycle that wrote the last operand byte already reflects that byte.

Top module: `intmath_coproc`

## Requirements
- R1: After reset every operand byte reads 0. Both products read 0, the sum reads 0, both quotients read 16'hFFFF and both remainders read 0.
- R2: Operand bytes are read back as written. Multi-byte fields are little-endian, with the lowest offset holding the least significant byte. Writes to result offsets or to offsets 44 to 63 change nothing. Offsets 44 to 63 read 8'h00.
- R3: Offsets 0x00 and 0x02 hold the 16-bit unsigned factors. Offsets 0x04 to 0x07 return their 32-bit unsigned product.
- R4: Offsets 0x08 and 0x0A hold the 16-bit two's-complement factors. Offsets 0x0C to 0x0F return their 32-bit two's-complement product.
- R5: For unsigned division, the divisor is at 0x10 and the dividend at 0x12. The quotient reads at 0x14 and the remainder at 0x16.
- R6: For signed division, the divisor is at 0x18 and the dividend at 0x1A. The quotient reads at 0x1C and the remainder at 0x1E. The quotient truncates toward zero and a nonzero remainder takes the dividend's sign. -32768 divided by -1 gives quotient 16'h8000 and remainder 0.
- R7: When the divisor is zero, the quotient reads 16'hFFFF and the remainder equals the dividend. This holds for both dividers.
- R8: Offsets 0x20 to 0x23 and 0x24 to 0x27 hold the two 32-bit addends. Offsets 0x28 to 0x2B return their sum modulo 2^32, and no carry is visible.
- R9: `rdata` follows `addr` in the same cycle. A write takes effect at the clock edge on which `wr` is high, so the next cycle's read already shows the updated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte offset into the window |
| wdata | input | 8 | Write byte |
| wr | input | 1 | Write strobe, sampled on the rising edge |
| rdata | output | 8 | Read byte at `addr` |

## Verification
A single address bus serves both writes and reads, so a write strobe can land on the same result offset that is being read. The bench writes a byte to a product offset and samples `rdata` for that offset in the same cycle and in the following cycle. Both samples must equal the computed product. The bench also reads each result in the first cycle after its last operand byte is written. It compares that read against arithmetic the bench computes itself, which shows that operand capture and result formation fall in adjacent cycles with no gap.

// File: rtl/intmath_coproc.sv
module intmath_coproc #(
  parameter int OPW = 16,
  parameter int ADW = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [$clog2(4*OPW/2+3*ADW/8)-1:0]     addr,
  input  logic [7:0]                             wdata,
  input  logic                                   wr,
  output logic [7:0]                             rdata
);
  localparam int OB     = OPW / 8;
  localparam int SB     = ADW / 8;
  localparam int UNIT   = 4 * OB;
  localparam int NBYTES = 4 * UNIT + 3 * SB;
  localparam int AW     = $clog2(NBYTES);
  localparam int UM = 0, SM = UNIT, UD = 2 * UNIT, SD = 3 * UNIT, AD = 4 * UNIT;
  localparam logic [AW-1:0] LAST = AW'(NBYTES - 1);

  logic [7:0] regs [NBYTES];
  logic [8*NBYTES-1:0] flat, res;

  function automatic logic is_op(input logic [AW-1:0] a);
    int ai;
    ai = int'(a);
    if (ai < AD) return (ai % UNIT) < 2 * OB;
    return ai < AD + 2 * SB;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < NBYTES; i++) regs[i] <= '0;
    else if (wr && is_op(addr)) regs[addr] <= wdata;

  always_comb for (int i = 0; i < NBYTES; i++) flat[8*i +: 8] = regs[i];

  logic [OPW-1:0] ua, ub, sa, sb, uden, unum, sden, snum;
  logic [ADW-1:0] adda, addb, sum;
  assign ua   = flat[8*UM +: OPW];
  assign ub   = flat[8*(UM+OB) +: OPW];
  assign sa   = flat[8*SM +: OPW];
  assign sb   = flat[8*(SM+OB) +: OPW];
  assign uden = flat[8*UD +: OPW];
  assign unum = flat[8*(UD+OB) +: OPW];
  assign sden = flat[8*SD +: OPW];
  assign snum = flat[8*(SD+OB) +: OPW];
  assign adda = flat[8*AD +: ADW];
  assign addb = flat[8*(AD+SB) +: ADW];

  logic [2*OPW-1:0] uprod, sprod;
  assign uprod = {{OPW{1'b0}}, ua} * {{OPW{1'b0}}, ub};
  assign sprod = $signed({{OPW{sa[OPW-1]}}, sa}) * $signed({{OPW{sb[OPW-1]}}, sb});

  logic [OPW-1:0] uq, ur;
  assign uq = (uden == '0) ? '1   : unum / uden;
  assign ur = (uden == '0) ? unum : unum % uden;

  logic [OPW-1:0] nmag, dmag, mq, mr, sq, sr;
  assign nmag = snum[OPW-1] ? -snum : snum;
  assign dmag = sden[OPW-1] ? -sden : sden;
  assign mq   = (dmag == '0) ? '0 : nmag / dmag;
  assign mr   = (dmag == '0) ? '0 : nmag % dmag;
  assign sq   = (sden == '0) ? '1   : ((snum[OPW-1] ^ sden[OPW-1]) ? -mq : mq);
  assign sr   = (sden == '0) ? snum : (snum[OPW-1] ? -mr : mr);

  assign sum = adda + addb;

  always_comb begin
    res = flat;
    res[8*(UM+2*OB) +: 2*OPW] = uprod;
    res[8*(SM+2*OB) +: 2*OPW] = sprod;
    res[8*(UD+2*OB) +: OPW]   = uq;
    res[8*(UD+3*OB) +: OPW]   = ur;
    res[8*(SD+2*OB) +: OPW]   = sq;
    res[8*(SD+3*OB) +: OPW]   = sr;
    res[8*(AD+2*SB) +: ADW]   = sum;
  end

  assign rdata = (addr <= LAST) ? res[{addr, 3'b000} +: 8] : 8'h00;

  logic [2*OPW-1:0] chk_u, chk_s;
  assign chk_u = {{OPW{1'b0}}, uq} * {{OPW{1'b0}}, uden} + {{OPW{1'b0}}, ur};
  assign chk_s = $signed({{OPW{sq[OPW-1]}}, sq}) * $signed({{OPW{sden[OPW-1]}}, sden})
               + {{OPW{sr[OPW-1]}}, sr};

  always_comb begin
    if (rst_n && ua != '0)
      a_r3_prod_factor: assert (uprod / {{OPW{1'b0}}, ua} == {{OPW{1'b0}}, ub});
    if (rst_n && sa != '0 && sb != '0)
      a_r4_prod_sign: assert (sprod[2*OPW-1] == (sa[OPW-1] ^ sb[OPW-1]));
    if (rst_n && uden != '0)
      a_r5_udiv_identity: assert (chk_u[OPW-1:0] == unum && ur < uden);
    if (rst_n && sden != '0)
      a_r6_sdiv_identity: assert (chk_s[OPW-1:0] == snum && (sr == '0 || sr[OPW-1] == snum[OPW-1]));
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr || !is_op(addr)) |=> $stable(flat));
endmodule

// File: tb/intmath_coproc_test.sv
module intmath_coproc_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int nchk = 0, nfail = 0;

  intmath_coproc uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr8(int a, logic [7:0] d);
    @(negedge clk); addr = 6'(a); wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask
  task automatic wr16(int a, logic [15:0] d);
    wr8(a, d[7:0]); wr8(a + 1, d[15:8]);
  endtask
  task automatic wr32(int a, logic [31:0] d);
    wr16(a, d[15:0]); wr16(a + 2, d[31:16]);
  endtask
  task automatic rd8(int a, output logic [7:0] d);
    @(negedge clk); addr = 6'(a); wr = 0; #1 d = rdata;
  endtask
  task automatic rd16(int a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd8(a, lo); rd8(a + 1, hi); d = {hi, lo};
  endtask
  task automatic rd32(int a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd16(a, lo); rd16(a + 2, hi); d = {hi, lo};
  endtask

  function automatic logic [15:0] pick(int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h0003;
      4: return 16'h007F;  5: return 16'h0080;  6: return 16'h00FF;  7: return 16'h0100;
      8: return 16'h7FFF;  9: return 16'h8000; 10: return 16'h8001; 11: return 16'hFFFE;
      12: return 16'hFFFF; 13: return 16'h1234; 14: return 16'hABCD; default: return 16'hFFF9;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] h;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd8(0, b);   check("R1 operand byte", 32'(b), 0);
    rd32(4, w);  check("R1 uprod", w, 0);
    rd32(12, w); check("R1 sprod", w, 0);
    rd32(40, w); check("R1 sum", w, 0);
    rd16(20, h); check("R1 uquot", 32'(h), 32'hFFFF);
    rd16(22, h); check("R1 urem", 32'(h), 0);
    rd16(28, h); check("R1 squot", 32'(h), 32'hFFFF);
    rd16(30, h); check("R1 srem", 32'(h), 0);

    // R2 byte order and ignored writes; R9 same-cycle result visibility
    wr16(0, 16'h1234);
    rd8(0, b); check("R2 low byte", 32'(b), 32'h34);
    rd8(1, b); check("R2 high byte", 32'(b), 32'h12);
    wr16(2, 16'h0010);
    rd32(4, w); check("R9 product after last write", w, 32'h00012340);
    @(negedge clk); addr = 6'd4; wdata = 8'h55; wr = 1; #1;
    check("R2 result read during write", 32'(rdata), 32'h40);
    @(posedge clk); #1 wr = 0;
    rd8(4, b); check("R2 result write ignored", 32'(b), 32'h40);
    wr8(50, 8'hA5);
    rd8(50, b); check("R2 out-of-map read", 32'(b), 0);
    rd8(44, b); check("R2 offset 44 read", 32'(b), 0);

    // R3/R4 multiplier sweeps
    for (int i = 0; i < 16; i++) begin
      wr16(0, pick(i)); wr16(8, pick(i));
      for (int j = 0; j < 16; j++) begin
        logic [31:0] eu;
        int es;
        wr16(2, pick(j)); wr16(10, pick(j));
        eu = {16'h0, pick(i)} * {16'h0, pick(j)};
        es = int'($signed(pick(i))) * int'($signed(pick(j)));
        rd32(4, w);  check("R3 unsigned product", w, eu);
        rd32(12, w); check("R4 signed product", w, 32'(es));
      end
    end

    // R5/R6/R7 divider sweeps
    for (int i = 0; i < 16; i++) begin
      wr16(16, pick(i)); wr16(24, pick(i));
      for (int j = 0; j < 16; j++) begin
        logic [15:0] qu, ru, qs, rs;
        int n, d;
        wr16(18, pick(j)); wr16(26, pick(j));
        if (pick(i) == 0) begin qu = 16'hFFFF; ru = pick(j); end
        else begin qu = pick(j) / pick(i); ru = pick(j) % pick(i); end
        n = int'($signed(pick(j))); d = int'($signed(pick(i)));
        if (d == 0) begin qs = 16'hFFFF; rs = pick(j); end
        else begin qs = 16'(n / d); rs = 16'(n % d); end
        rd16(20, h); check(d == 0 ? "R7 unsigned quotient" : "R5 unsigned quotient", 32'(h), 32'(qu));
        rd16(22, h); check(d == 0 ? "R7 unsigned remainder" : "R5 unsigned remainder", 32'(h), 32'(ru));
        rd16(28, h); check(d == 0 ? "R7 signed quotient" : "R6 signed quotient", 32'(h), 32'(qs));
        rd16(30, h); check(d == 0 ? "R7 signed remainder" : "R6 signed remainder", 32'(h), 32'(rs));
      end
    end
    wr16(24, 16'hFFFF); wr16(26, 16'h8000);
    rd16(28, h); check("R6 min over minus one quotient", 32'(h), 32'h8000);
    rd16(30, h); check("R6 min over minus one remainder", 32'(h), 0);

    // R8 adder sweep with wrap
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        logic [31:0] a, c;
        a = {pick(i), pick(j)}; c = {pick(j), pick(15 - i)};
        wr32(32, a); wr32(36, c);
        rd32(40, w); check("R8 sum", w, a + c);
      end
    wr32(32, 32'hFFFFFFFF); wr32(36, 32'h00000002);
    rd32(40, w); check("R8 wrap", w, 32'h00000001);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule